// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and four external request pins. It drives a standard interrupt request and a separate fast interrupt request towards a processor. Every standard source has its own priority level (one of eight), an enable bit, a trigger mode and a vector. The controller finds the highest-priority pending, enabled source and raises the standard request when that source outranks the level currently in service.

Software works through a small register bus. Per-source configuration words are written at addresses 0 to NSRC-1. A read of the acknowledge address returns the winning source's vector and enters that level into service. A write to the end-of-interrupt address leaves the current level. Levels nest on an eight-deep stack. The fast request comes only from its own dedicated pin, through a synchroniser. No standard source can reach it.

Top module: `vpic_top`

## Requirements
- R1: After reset, irq_o and fiq_o are 0. Every source is disabled with mode 00, level 0 and vector 0. The spurious vector is 8'hFF.
- R2: A write to address i (i < NSRC) sets source i's configuration. The word has priority in bits [2:0] (7 is the highest), enable in bit [3], mode in bits [5:4] and vector in bits [VEC_W+5:6]. Internal sources are 0..N_INT-1. External sources follow them.
- R3: An internal source with mode bit [1] = 0 is pending while its input is high. With mode bit [1] = 1 it latches a pending bit on a rising edge. Mode bit [0] is ignored for internal sources.
- R4: The four external modes are 00 high level, 01 low level, 10 rising edge and 11 falling edge. External inputs pass through a two-flop synchroniser before detection.
- R5: A latched edge stays pending until that source's vector is acknowledged. Acknowledging the source clears the latched edge. End-of-interrupt does not clear it. A level source is never cleared by acknowledge.
- R6: A disabled source never raises irq_o and is never returned by acknowledge.
- R7: A read at address NSRC returns the vector of the highest-priority pending enabled source on bus_rdata_o in the cycle after the read. Among sources of equal priority, the lowest index wins.
- R8: An acknowledge pushes the winner's level onto the stack. While the stack is non-empty, irq_o rises only for a pending level strictly above the top entry. A write at address NSRC+1 pops one entry. A pop on an empty stack is ignored.
- R9: If a read at NSRC finds no source able to raise irq_o, it returns the spurious vector and leaves the stack unchanged. The spurious vector is written with bits [VEC_W-1:0] at address NSRC+2.
- R10: fiq_o equals fast_req_i delayed by two clock cycles. The standard sources do not affect fiq_o, and fast_req_i does not affect irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | N_INT | Internal peripheral requests |
| ext_src_i | input | N_EXT | External request pins (asynchronous) |
| fast_req_i | input | 1 | Dedicated fast request pin (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | VEC_W+6 | Write data |
| bus_rdata_o | output | VEC_W | Read data (vector), valid the cycle after a read |
| irq_o | output | 1 | Standard interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A corrupted service stack shows up quickly at the ports. irq_o is masked or released on the wrong level, and this is visible within the cycle after the acknowledge or end-of-interrupt that caused it. The next acknowledge then returns the spurious vector or the wrong vector. A stuck or lost edge latch shows as irq_o remaining high, or never rising, a few cycles after the pulse. Priority and tie-break faults show in the vector returned one cycle after the read. The bench sweeps every pair of sources under three priority assignments, which include ties.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    localparam int LVL_W = 3;
    localparam int NLVL  = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/vpic_sync.sv
module vpic_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[1];
endmodule

// File: rtl/vpic_detect.sv
module vpic_detect #(
    parameter bit IS_EXT = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_i,
    input  logic [1:0] mode_i,
    input  logic       ack_i,
    output logic       pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } det_t;

    det_t det_d, det_q;
    logic s, x, is_edge, inv, rise;

    if (IS_EXT) begin : g_sync
        vpic_sync u_sync (.clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(s));
    end else begin : g_raw
        assign s = src_i;
    end

    always_comb begin
        is_edge    = mode_i[1];
        inv        = IS_EXT && mode_i[0];
        x          = s ^ inv;
        rise       = x && !det_q.prev;
        det_d.prev = x;
        det_d.pend = is_edge && (rise || (det_q.pend && !ack_i));
        pend_o     = is_edge ? det_q.pend : x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    // R5: acknowledge clears a latched edge unless a new edge arrives
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !rise) |=> !det_q.pend);
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb import vpic_pkg::*; #(
    parameter int NSRC = 8,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]            pend_i,
    input  logic [NSRC-1:0]            en_i,
    input  logic [NSRC-1:0][LVL_W-1:0] prio_i,
    output logic                       valid_o,
    output logic [IW-1:0]              idx_o,
    output lvl_t                       lvl_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i] && en_i[i] && (!valid_o || prio_i[i] > lvl_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
                lvl_o   = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/vpic_top.sv
module vpic_top import vpic_pkg::*; #(
    parameter int N_INT = 4,
    parameter int N_EXT = 4,
    parameter int VEC_W = 8,
    localparam int NSRC = N_INT + N_EXT,
    localparam int AW   = $clog2(NSRC + 3),
    localparam int DW   = VEC_W + 6,
    localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int SPW  = LVL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_src_i,
    input  logic [N_EXT-1:0] ext_src_i,
    input  logic             fast_req_i,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic [AW-1:0]    bus_addr_i,
    input  logic [DW-1:0]    bus_wdata_i,
    output logic [VEC_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic             fiq_o
);
    typedef struct packed {
        logic [NLVL-1:0][LVL_W-1:0] stk;
        logic [SPW-1:0]             sp;
        logic [VEC_W-1:0]           spur;
        logic [VEC_W-1:0]           rdata;
        logic [NSRC-1:0][LVL_W-1:0] prio;
        logic [NSRC-1:0]            en;
        logic [NSRC-1:0][1:0]       mode;
        logic [NSRC-1:0][VEC_W-1:0] vec;
    } st_t;

    st_t st_d, st_q;

    logic [NSRC-1:0] raw, pend, ack_src;
    logic            win_valid, serve, ack, eoi;
    logic [IW-1:0]   win_idx;
    lvl_t            win_lvl, top_lvl;
    logic [LVL_W-1:0] top_ptr, below_ptr;

    assign raw = {ext_src_i, int_src_i};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        vpic_detect #(.IS_EXT(i >= N_INT)) u_det (
            .clk(clk), .rst_n(rst_n), .src_i(raw[i]),
            .mode_i(st_q.mode[i]), .ack_i(ack_src[i]), .pend_o(pend[i])
        );
    end

    vpic_arb #(.NSRC(NSRC)) u_arb (
        .pend_i(pend), .en_i(st_q.en), .prio_i(st_q.prio),
        .valid_o(win_valid), .idx_o(win_idx), .lvl_o(win_lvl)
    );

    vpic_sync u_fsync (.clk(clk), .rst_n(rst_n), .d_i(fast_req_i), .q_o(fiq_o));

    always_comb begin
        top_ptr   = st_q.sp[LVL_W-1:0] - 1'b1;
        below_ptr = st_q.sp[LVL_W-1:0] - 2'd2;
        top_lvl   = st_q.stk[top_ptr];
        serve     = win_valid && ((st_q.sp == '0) || (win_lvl > top_lvl));
        ack       = bus_rd_i && (bus_addr_i == AW'(NSRC));
        eoi       = bus_wr_i && (bus_addr_i == AW'(NSRC + 1));
        ack_src   = '0;
        st_d      = st_q;

        for (int i = 0; i < NSRC; i++) begin
            if (bus_wr_i && (bus_addr_i == AW'(i))) begin
                st_d.prio[i] = bus_wdata_i[2:0];
                st_d.en[i]   = bus_wdata_i[3];
                st_d.mode[i] = bus_wdata_i[5:4];
                st_d.vec[i]  = bus_wdata_i[VEC_W+5:6];
            end
        end
        if (bus_wr_i && (bus_addr_i == AW'(NSRC + 2)))
            st_d.spur = bus_wdata_i[VEC_W-1:0];

        if (ack) begin
            if (serve) begin
                st_d.rdata                      = st_q.vec[win_idx];
                st_d.stk[st_q.sp[LVL_W-1:0]]    = win_lvl;
                st_d.sp                         = st_q.sp + 1'b1;
                ack_src[win_idx]                = 1'b1;
            end else begin
                st_d.rdata = st_q.spur;
            end
        end else if (eoi && (st_q.sp != '0)) begin
            st_d.sp = st_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.spur <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o       = serve;
    assign bus_rdata_o = st_q.rdata;

    // R8: stack depth never exceeds the number of levels
    a_r8_stack_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sp <= SPW'(NLVL));
    // R8: nested levels on the stack are strictly increasing
    a_r8_stack_rising: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sp >= SPW'(2)) |-> (st_q.stk[top_ptr] > st_q.stk[below_ptr]));
    // R8: end-of-interrupt pops exactly one entry
    a_r8_eoi_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack && st_q.sp != '0) |=> (st_q.sp == $past(st_q.sp) - 1'b1));
    // R9: unserviceable acknowledge returns spurious vector, stack unchanged
    a_r9_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_o) |=> (bus_rdata_o == $past(st_q.spur) && $stable(st_q.sp)));
    // R6: the arbiter only picks an enabled, pending source
    a_r6_win_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (st_q.en[win_idx] && pend[win_idx]));
    // R10: fast output is the fast pin two cycles late
    a_r10_fast_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (fiq_o == $past(fast_req_i, 2)));
endmodule

// File: tb/tb_vpic_top.sv
module tb_vpic_top;
    localparam int N_INT = 4, N_EXT = 4, VEC_W = 8;
    localparam int NSRC = N_INT + N_EXT;
    localparam int AW = $clog2(NSRC + 3);
    localparam int DW = VEC_W + 6;
    localparam int A_ACK = NSRC, A_EOI = NSRC + 1, A_SPUR = NSRC + 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N_INT-1:0] int_src = '0;
    logic [N_EXT-1:0] ext_src = '0;
    logic fast_req = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [VEC_W-1:0] bus_rdata;
    logic irq, fiq;

    int checks = 0, errors = 0;
    logic [VEC_W-1:0] v;

    always #2.5 clk = ~clk;

    vpic_top #(.N_INT(N_INT), .N_EXT(N_EXT), .VEC_W(VEC_W)) dut (
        .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_src_i(ext_src),
        .fast_req_i(fast_req), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .fiq_o(fiq));

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wr(int a, int d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd_ack(output logic [VEC_W-1:0] r);
        bus_rd = 1'b1; bus_addr = AW'(A_ACK);
        tick();
        bus_rd = 1'b0;
        r = bus_rdata;
    endtask

    function automatic int cfg(int prio, int en, int mode, int vec);
        return (vec << 6) | (mode << 4) | (en << 3) | prio;
    endfunction

    task automatic set_src(logic [NSRC-1:0] m);
        int_src = m[N_INT-1:0];
        ext_src = m[NSRC-1:N_INT];
    endtask

    function automatic int pr(int i, int k);
        return ((i * (k + 1)) >> 1) % 8;
    endfunction

    function automatic int winner(int a, int b, int k);
        if (pr(b, k) > pr(a, k)) return b;
        if (pr(a, k) > pr(b, k)) return a;
        return (a < b) ? a : b;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 irq after reset", irq, 0);
        chk("R1 fiq after reset", fiq, 0);
        set_src('1);
        tick(4);
        chk("R1 all sources disabled", irq, 0);
        rd_ack(v);
        chk("R1 spurious reset value", v, 8'hFF);
        set_src('0);
        tick(4);

        // R2 R7: pair sweep with level-high sources under three priority maps
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NSRC; i++) wr(i, cfg(pr(i, k), 1, 0, 8'h40 + i));
            for (int a = 0; a < NSRC; a++) begin
                for (int b = 0; b < NSRC; b++) begin
                    logic [NSRC-1:0] m;
                    m = '0; m[a] = 1'b1; m[b] = 1'b1;
                    set_src(m);
                    tick(4);
                    chk("R3 R4 level pending raises irq", irq, 1);
                    rd_ack(v);
                    chk("R7 winner vector", v, 8'h40 + winner(a, b, k));
                    chk("R8 equal or lower level held off", irq, 0);
                    chk("R10 sources do not reach fiq", fiq, 0);
                    wr(A_EOI, 0);
                    set_src('0);
                    tick(4);
                end
            end
        end

        // R6: masking
        for (int i = 0; i < NSRC; i++) wr(i, cfg(i, 1, 0, 8'h60 + i));
        wr(2, cfg(7, 0, 0, 8'h62));
        set_src(8'b0000_0100);
        tick(4);
        chk("R6 masked source no irq", irq, 0);
        rd_ack(v);
        chk("R6 masked source spurious", v, 8'hFF);
        set_src(8'b0010_0100);
        tick(4);
        rd_ack(v);
        chk("R6 masked higher source skipped", v, 8'h65);
        wr(A_EOI, 0);
        set_src('0);
        tick(4);

        // R9: programmable spurious vector
        wr(A_SPUR, 8'h5A);
        rd_ack(v);
        chk("R9 programmed spurious", v, 8'h5A);

        // R8: nesting
        wr(0, cfg(2, 1, 0, 8'hA0));
        wr(1, cfg(5, 1, 0, 8'hA1));
        wr(2, cfg(3, 1, 0, 8'hA2));
        wr(4, cfg(7, 1, 0, 8'hA4));
        set_src(8'b0000_0001);
        tick(4);
        rd_ack(v);
        chk("R8 first level vector", v, 8'hA0);
        set_src(8'b0000_0011);
        tick(2);
        chk("R8 higher level preempts", irq, 1);
        rd_ack(v);
        chk("R8 nested vector", v, 8'hA1);
        set_src(8'b0000_0111);
        tick(2);
        chk("R8 lower level held off", irq, 0);
        rd_ack(v);
        chk("R9 spurious while nested", v, 8'h5A);
        set_src(8'b0000_0101);
        tick(2);
        wr(A_EOI, 0);
        chk("R9 stack unchanged so level 2 remains", irq, 1);
        rd_ack(v);
        chk("R8 after pop vector", v, 8'hA2);
        set_src(8'b0001_0101);
        tick(4);
        rd_ack(v);
        chk("R8 third nesting vector", v, 8'hA4);
        wr(A_EOI, 0); wr(A_EOI, 0); wr(A_EOI, 0);
        chk("R8 empty stack serves any level", irq, 1);
        wr(A_EOI, 0);
        set_src('0);
        tick(4);
        chk("R8 idle after pops", irq, 0);
        set_src(8'b0000_0001);
        tick(2);
        chk("R8 pop on empty ignored", irq, 1);
        rd_ack(v);
        chk("R8 pop on empty ignored vector", v, 8'hA0);
        chk("R8 pop on empty ignored serviced", irq, 0);
        wr(A_EOI, 0);
        set_src('0);
        tick(4);

        // R3 R5: internal rising edge latch
        wr(0, cfg(1, 1, 2, 8'hB0));
        int_src[0] = 1'b1; tick(); int_src[0] = 1'b0;
        tick(2);
        chk("R5 edge latched", irq, 1);
        rd_ack(v);
        chk("R5 edge vector", v, 8'hB0);
        wr(A_EOI, 0);
        chk("R5 edge cleared by ack", irq, 0);
        wr(1, cfg(1, 1, 3, 8'hB1));
        int_src[1] = 1'b1; tick(3);
        chk("R3 mode bit0 ignored internal rising", irq, 1);
        int_src[1] = 1'b0; tick(2);
        chk("R5 edge stays after input drops", irq, 1);
        rd_ack(v);
        chk("R3 internal edge vector", v, 8'hB1);
        wr(A_EOI, 0);
        chk("R3 no falling trigger internal", irq, 0);

        // R4: external falling edge
        wr(5, cfg(4, 0, 0, 8'hB5));
        ext_src[1] = 1'b1; tick(4);
        wr(5, cfg(4, 1, 3, 8'hB5));
        tick(4);
        chk("R4 falling idle high no irq", irq, 0);
        ext_src[1] = 1'b0; tick(); ext_src[1] = 1'b1;
        tick(5);
        chk("R4 falling edge latched", irq, 1);
        rd_ack(v);
        chk("R4 falling vector", v, 8'hB5);
        wr(A_EOI, 0);
        chk("R5 falling edge cleared", irq, 0);

        // R4 R5: external low level
        wr(6, cfg(4, 0, 0, 8'hB6));
        ext_src[2] = 1'b1; tick(4);
        wr(6, cfg(4, 1, 1, 8'hB6));
        tick(4);
        chk("R4 low level inactive high", irq, 0);
        ext_src[2] = 1'b0; tick(4);
        chk("R4 low level active", irq, 1);
        rd_ack(v);
        chk("R4 low level vector", v, 8'hB6);
        wr(A_EOI, 0);
        chk("R5 level not cleared by ack", irq, 1);
        ext_src[2] = 1'b1; tick(4);
        chk("R4 low level released", irq, 0);

        // R4: external rising edge
        wr(7, cfg(4, 1, 2, 8'hB7));
        ext_src[3] = 1'b1; tick(); ext_src[3] = 1'b0;
        tick(5);
        chk("R4 rising edge latched", irq, 1);
        rd_ack(v);
        chk("R4 rising vector", v, 8'hB7);
        wr(A_EOI, 0);
        chk("R4 rising cleared", irq, 0);

        // R10: fast path timing
        fast_req = 1'b1;
        tick();
        chk("R10 fiq one cycle", fiq, 0);
        tick();
        chk("R10 fiq two cycles", fiq, 1);
        chk("R10 fast does not drive irq", irq, 0);
        fast_req = 1'b0;
        tick();
        chk("R10 fiq hold one cycle", fiq, 1);
        tick();
        chk("R10 fiq released", fiq, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule